// File: doc/BRIEF.md
# Banked Scratchpad Bank-Side Controller

This block is the bank side of a multi-bank local scratchpad memory. An address-routed crossbar sits in front of it. The crossbar resolves conflicts between requesters, removes the bank-select bits from the address, and hands each bank at most one request per cycle on its own port. Inside the block, every bank has a one-port synchronous RAM and a small response stage.

A read always produces a response one cycle after it is accepted. That response carries the stored word and echoes the request's tag, core identifier and unique identifier. A write updates the bank's RAM. It returns an acknowledgement only when the `wr_ack_en` configuration input is set. A bank with a response that has not been taken holds that response and refuses new work, which pushes back-pressure into the crossbar.

Across all banks the block counts accepted reads and accepted writes. It also reports a bank-stall figure, which is the crossbar's own collision count passed straight through, because no bank ever stalls internally.

Top module: `spm_frontend`

## Requirements
- R1: There are 2^BANK_BITS banks (4 by default), each with its own request and response port. The request carries a LINE_BITS-wide line index with the bank-select bits already removed. Banks are independent, and all of them may accept a request in the same cycle.
- R2: A bank accepts a request on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever that bank has no response pending, or its pending response is being taken (`rsp_ready` high).
- R3: An accepted read sets that bank's `rsp_valid` at the same edge, so it is visible in the following cycle. In that cycle `rsp_write` is 0 and `rsp_data` is the word last written to the addressed line of that bank.
- R4: Every response echoes the `req_tag`, `req_cid` and `req_uid` of the request that caused it.
- R5: An accepted write stores `req_wdata` at the addressed line. With `wr_ack_en` at 0 it produces no response: `rsp_valid` is 0 in the following cycle.
- R6: With `wr_ack_en` at 1, an accepted write produces a response in the following cycle with `rsp_write` at 1 and the echoed fields.
- R7: While `rsp_valid` is high and `rsp_ready` is low, the response and its fields stay unchanged, `req_ready` is low, and an offered request is neither accepted nor counted.
- R8: `rd_count` and `wr_count` each grow by the number of reads or writes accepted across all banks at an edge. The new value is visible after that edge, and both counters wrap modulo 2^CNT_W.
- R9: `stall_count` equals the `xbar_collisions` input in the same cycle.
- R10: After synchronous reset, all `rsp_valid` bits are 0, all `req_ready` bits are 1, and both counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ack_en | input | 1 | Enables acknowledgements for writes |
| req_valid | input | NB | Per-bank request present |
| req_ready | output | NB | Per-bank request accepted this edge |
| req_write | input | NB | Per-bank: 1 write, 0 read |
| req_line | input | NB x LINE_BITS | Per-bank line index |
| req_wdata | input | NB x DATA_W | Per-bank write data |
| req_tag | input | NB x TAG_W | Per-bank request tag |
| req_cid | input | NB x CID_W | Per-bank core identifier |
| req_uid | input | NB x UID_W | Per-bank unique identifier |
| rsp_valid | output | NB | Per-bank response present |
| rsp_ready | input | NB | Per-bank response taken |
| rsp_write | output | NB | Response is a write acknowledgement |
| rsp_data | output | NB x DATA_W | Read data |
| rsp_tag | output | NB x TAG_W | Echoed tag |
| rsp_cid | output | NB x CID_W | Echoed core identifier |
| rsp_uid | output | NB x UID_W | Echoed unique identifier |
| rd_count | output | CNT_W | Accepted reads |
| wr_count | output | CNT_W | Accepted writes |
| xbar_collisions | input | COLL_W | Collision count from the crossbar |
| stall_count | output | COLL_W | Reported bank-stall count |

## Verification
A table of writes and read-backs exercises the data path. It hits the same line index in two banks, which would show banks aliasing onto each other. It also hits the lowest and highest line index, which would show a sliced or truncated line address. Separate patterns probe the response rules:
- Writes with acknowledgements off and then on separate the two response policies.
- A read that is held under `rsp_ready` low while a write waits shows whether the response is frozen and the waiting request is blocked and left uncounted.
- A cycle with reads on all banks at once checks that the banks are independent and that the counter adds several events per edge.

// File: rtl/spm_pkg.sv
package spm_pkg;

    // Kind of response returned by a bank.
    typedef enum logic {
        RSP_READ  = 1'b0,
        RSP_WRITE = 1'b1
    } rsp_kind_e;

    // A bank answers a read always, a write only when acknowledgements are on.
    function automatic logic needs_response(input logic is_write, input logic ack_en);
        return !is_write || ack_en;
    endfunction

endpackage

// File: rtl/spm_bank_ram.sv
module spm_bank_ram #(
    parameter int LINE_BITS = 4,
    parameter int DATA_W    = 16,
    localparam int DEPTH    = 1 << LINE_BITS
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [LINE_BITS-1:0] line,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rdata
);

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[line] <= wdata;
        end
        if (rd_en) begin
            rdata <= store[line];
        end
    end

endmodule

// File: rtl/spm_bank_port.sv
module spm_bank_port
    import spm_pkg::*;
#(
    parameter int LINE_BITS = 4,
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 4,
    parameter int CID_W     = 2,
    parameter int UID_W     = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_ack_en,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [LINE_BITS-1:0] req_line,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [TAG_W-1:0]     req_tag,
    input  logic [CID_W-1:0]     req_cid,
    input  logic [UID_W-1:0]     req_uid,
    output logic                 rsp_valid,
    input  logic                 rsp_ready,
    output logic                 rsp_write,
    output logic [DATA_W-1:0]    rsp_data,
    output logic [TAG_W-1:0]     rsp_tag,
    output logic [CID_W-1:0]     rsp_cid,
    output logic [UID_W-1:0]     rsp_uid,
    output logic                 took_read,
    output logic                 took_write
);

    typedef struct packed {
        rsp_kind_e         kind;
        logic [TAG_W-1:0]  tag;
        logic [CID_W-1:0]  cid;
        logic [UID_W-1:0]  uid;
    } rsp_meta_t;

    rsp_meta_t meta_q, meta_d;
    logic      valid_q;
    logic      accept;

    assign req_ready  = !valid_q || rsp_ready;
    assign accept     = req_valid && req_ready;
    assign took_read  = accept && !req_write;
    assign took_write = accept && req_write;

    always_comb begin
        meta_d.kind = req_write ? RSP_WRITE : RSP_READ;
        meta_d.tag  = req_tag;
        meta_d.cid  = req_cid;
        meta_d.uid  = req_uid;
    end

    spm_bank_ram #(
        .LINE_BITS (LINE_BITS),
        .DATA_W    (DATA_W)
    ) u_ram (
        .clk   (clk),
        .wr_en (took_write),
        .rd_en (took_read),
        .line  (req_line),
        .wdata (req_wdata),
        .rdata (rsp_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            meta_q  <= '0;
        end else if (accept && needs_response(req_write, wr_ack_en)) begin
            valid_q <= 1'b1;
            meta_q  <= meta_d;
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rsp_valid = valid_q;
    assign rsp_write = (meta_q.kind == RSP_WRITE);
    assign rsp_tag   = meta_q.tag;
    assign rsp_cid   = meta_q.cid;
    assign rsp_uid   = meta_q.uid;

endmodule

// File: rtl/spm_evt_counter.sv
module spm_evt_counter #(
    parameter int N     = 4,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [N-1:0]     hits,
    output logic [CNT_W-1:0] count
);

    logic [CNT_W-1:0] inc;

    always_comb begin
        inc = '0;
        for (int i = 0; i < N; i++) begin
            inc = inc + CNT_W'(hits[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            count <= count + inc;
        end
    end

endmodule

// File: rtl/spm_frontend.sv
module spm_frontend #(
    parameter int BANK_BITS = 2,
    parameter int LINE_BITS = 4,
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 4,
    parameter int CID_W     = 2,
    parameter int UID_W     = 6,
    parameter int CNT_W     = 16,
    parameter int COLL_W    = 16,
    localparam int NB       = 1 << BANK_BITS
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_ack_en,
    input  logic [NB-1:0]                   req_valid,
    output logic [NB-1:0]                   req_ready,
    input  logic [NB-1:0]                   req_write,
    input  logic [NB-1:0][LINE_BITS-1:0]    req_line,
    input  logic [NB-1:0][DATA_W-1:0]       req_wdata,
    input  logic [NB-1:0][TAG_W-1:0]        req_tag,
    input  logic [NB-1:0][CID_W-1:0]        req_cid,
    input  logic [NB-1:0][UID_W-1:0]        req_uid,
    output logic [NB-1:0]                   rsp_valid,
    input  logic [NB-1:0]                   rsp_ready,
    output logic [NB-1:0]                   rsp_write,
    output logic [NB-1:0][DATA_W-1:0]       rsp_data,
    output logic [NB-1:0][TAG_W-1:0]        rsp_tag,
    output logic [NB-1:0][CID_W-1:0]        rsp_cid,
    output logic [NB-1:0][UID_W-1:0]        rsp_uid,
    output logic [CNT_W-1:0]                rd_count,
    output logic [CNT_W-1:0]                wr_count,
    input  logic [COLL_W-1:0]               xbar_collisions,
    output logic [COLL_W-1:0]               stall_count
);

    logic [NB-1:0] took_read;
    logic [NB-1:0] took_write;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        spm_bank_port #(
            .LINE_BITS (LINE_BITS),
            .DATA_W    (DATA_W),
            .TAG_W     (TAG_W),
            .CID_W     (CID_W),
            .UID_W     (UID_W)
        ) u_port (
            .clk        (clk),
            .rst        (rst),
            .wr_ack_en  (wr_ack_en),
            .req_valid  (req_valid[b]),
            .req_ready  (req_ready[b]),
            .req_write  (req_write[b]),
            .req_line   (req_line[b]),
            .req_wdata  (req_wdata[b]),
            .req_tag    (req_tag[b]),
            .req_cid    (req_cid[b]),
            .req_uid    (req_uid[b]),
            .rsp_valid  (rsp_valid[b]),
            .rsp_ready  (rsp_ready[b]),
            .rsp_write  (rsp_write[b]),
            .rsp_data   (rsp_data[b]),
            .rsp_tag    (rsp_tag[b]),
            .rsp_cid    (rsp_cid[b]),
            .rsp_uid    (rsp_uid[b]),
            .took_read  (took_read[b]),
            .took_write (took_write[b])
        );
    end

    spm_evt_counter #(.N(NB), .CNT_W(CNT_W)) u_rd_cnt (
        .clk   (clk),
        .rst   (rst),
        .hits  (took_read),
        .count (rd_count)
    );

    spm_evt_counter #(.N(NB), .CNT_W(CNT_W)) u_wr_cnt (
        .clk   (clk),
        .rst   (rst),
        .hits  (took_write),
        .count (wr_count)
    );

    // Conflicts are settled in the crossbar, so its collision figure is the stall figure.
    assign stall_count = xbar_collisions;

endmodule

// File: rtl/spm_frontend_chk.sv
module spm_frontend_chk #(
    parameter int BANK_BITS = 2,
    parameter int LINE_BITS = 4,
    parameter int DATA_W    = 16,
    parameter int TAG_W     = 4,
    parameter int CID_W     = 2,
    parameter int UID_W     = 6,
    parameter int CNT_W     = 16,
    parameter int COLL_W    = 16,
    localparam int NB       = 1 << BANK_BITS
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_ack_en,
    input logic [NB-1:0]                req_valid,
    input logic [NB-1:0]                req_ready,
    input logic [NB-1:0]                req_write,
    input logic [NB-1:0][LINE_BITS-1:0] req_line,
    input logic [NB-1:0][DATA_W-1:0]    req_wdata,
    input logic [NB-1:0][TAG_W-1:0]     req_tag,
    input logic [NB-1:0][CID_W-1:0]     req_cid,
    input logic [NB-1:0][UID_W-1:0]     req_uid,
    input logic [NB-1:0]                rsp_valid,
    input logic [NB-1:0]                rsp_ready,
    input logic [NB-1:0]                rsp_write,
    input logic [NB-1:0][DATA_W-1:0]    rsp_data,
    input logic [NB-1:0][TAG_W-1:0]     rsp_tag,
    input logic [NB-1:0][CID_W-1:0]     rsp_cid,
    input logic [NB-1:0][UID_W-1:0]     rsp_uid,
    input logic [CNT_W-1:0]             rd_count,
    input logic [CNT_W-1:0]             wr_count,
    input logic [COLL_W-1:0]            xbar_collisions,
    input logic [COLL_W-1:0]            stall_count
);

    logic [NB-1:0] rd_acc;
    logic [NB-1:0] wr_acc;
    assign rd_acc = req_valid & req_ready & ~req_write;
    assign wr_acc = req_valid & req_ready & req_write;

    for (genvar b = 0; b < NB; b++) begin : g_chk
        p_read_rsp_r3: assert property (@(posedge clk) disable iff (rst)
            rd_acc[b] |=> (rsp_valid[b] && !rsp_write[b]));

        p_echo_r4: assert property (@(posedge clk) disable iff (rst)
            (rd_acc[b] || (wr_acc[b] && wr_ack_en)) |=>
            (rsp_tag[b] == $past(req_tag[b]) && rsp_cid[b] == $past(req_cid[b])
             && rsp_uid[b] == $past(req_uid[b])));

        p_silent_write_r5: assert property (@(posedge clk) disable iff (rst)
            (wr_acc[b] && !wr_ack_en) |=> !rsp_valid[b]);

        p_write_ack_r6: assert property (@(posedge clk) disable iff (rst)
            (wr_acc[b] && wr_ack_en) |=> (rsp_valid[b] && rsp_write[b]));

        p_hold_r7: assert property (@(posedge clk) disable iff (rst)
            (rsp_valid[b] && !rsp_ready[b]) |=>
            (rsp_valid[b] && $stable(rsp_tag[b]) && $stable(rsp_data[b])
             && $stable(rsp_write[b])));
    end

    p_rd_count_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> rd_count == CNT_W'($past(rd_count) + CNT_W'($countones($past(rd_acc)))));

    p_wr_count_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> wr_count == CNT_W'($past(wr_count) + CNT_W'($countones($past(wr_acc)))));

    p_reset_state_r10: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rsp_valid == '0 && rd_count == '0 && wr_count == '0));

endmodule

bind spm_frontend spm_frontend_chk #(
    .BANK_BITS (BANK_BITS),
    .LINE_BITS (LINE_BITS),
    .DATA_W    (DATA_W),
    .TAG_W     (TAG_W),
    .CID_W     (CID_W),
    .UID_W     (UID_W),
    .CNT_W     (CNT_W),
    .COLL_W    (COLL_W)
) u_chk (.*);

// File: tb/spm_frontend_test.sv
`timescale 1ns/1ps
module spm_frontend_test;

    localparam int NB = 4;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 wr_ack_en = 1'b0;
    logic [NB-1:0]        req_valid = '0;
    logic [NB-1:0]        req_ready;
    logic [NB-1:0]        req_write = '0;
    logic [NB-1:0][3:0]   req_line = '0;
    logic [NB-1:0][15:0]  req_wdata = '0;
    logic [NB-1:0][3:0]   req_tag = '0;
    logic [NB-1:0][1:0]   req_cid = '0;
    logic [NB-1:0][5:0]   req_uid = '0;
    logic [NB-1:0]        rsp_valid;
    logic [NB-1:0]        rsp_ready = '1;
    logic [NB-1:0]        rsp_write;
    logic [NB-1:0][15:0]  rsp_data;
    logic [NB-1:0][3:0]   rsp_tag;
    logic [NB-1:0][1:0]   rsp_cid;
    logic [NB-1:0][5:0]   rsp_uid;
    logic [15:0]          rd_count;
    logic [15:0]          wr_count;
    logic [15:0]          xbar_collisions = '0;
    logic [15:0]          stall_count;

    spm_frontend uut (.*);

    always #4 clk = ~clk;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;
    int exp_rd   = 0;
    int exp_wr   = 0;
    logic [15:0] mirror [NB][16];

    // {write, bank[1:0], line[3:0], data[15:0]}
    localparam logic [22:0] VEC [8] = '{
        {1'b1, 2'd0, 4'd3,  16'h1234},
        {1'b1, 2'd1, 4'd3,  16'hBEEF},
        {1'b0, 2'd0, 4'd3,  16'h0000},
        {1'b0, 2'd1, 4'd3,  16'h0000},
        {1'b1, 2'd3, 4'd15, 16'hA5A5},
        {1'b0, 2'd3, 4'd15, 16'h0000},
        {1'b1, 2'd2, 4'd0,  16'h0F0F},
        {1'b0, 2'd2, 4'd0,  16'h0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Present one request at a negedge, let one edge take it, then withdraw it.
    task automatic send(input int b, input logic wr, input logic [3:0] line,
                        input logic [15:0] d, input logic [3:0] tag,
                        input logic [1:0] cid, input logic [5:0] uid);
        req_valid[b] = 1'b1;
        req_write[b] = wr;
        req_line[b]  = line;
        req_wdata[b] = d;
        req_tag[b]   = tag;
        req_cid[b]   = cid;
        req_uid[b]   = uid;
        @(posedge clk);
        @(negedge clk);
        req_valid[b] = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 rsp_valid", 32'(rsp_valid), 32'h0);
        chk("R10 req_ready", 32'(req_ready), 32'hF);
        chk("R10 rd_count", 32'(rd_count), 32'h0);
        chk("R10 wr_count", 32'(wr_count), 32'h0);

        // Table walk, acknowledgements off
        for (int i = 0; i < 8; i++) begin
            logic [22:0] v;
            int b;
            v = VEC[i];
            b = int'(v[21:20]);
            send(b, v[22], v[19:16], v[15:0], 4'(i), 2'(i), 6'(i + 32));
            if (v[22]) begin
                mirror[b][v[19:16]] = v[15:0];
                exp_wr++;
                chk("R5 no write response", 32'(rsp_valid[b]), 32'h0);
            end else begin
                exp_rd++;
                chk("R3 read valid", 32'(rsp_valid[b]), 32'h1);
                chk("R3 read kind", 32'(rsp_write[b]), 32'h0);
                chk("R3 R1 read data", 32'(rsp_data[b]), 32'(mirror[b][v[19:16]]));
                chk("R4 tag", 32'(rsp_tag[b]), 32'(i));
                chk("R4 cid", 32'(rsp_cid[b]), 32'(i % 4));
                chk("R4 uid", 32'(rsp_uid[b]), 32'(i + 32));
            end
        end
        chk("R8 reads after table", 32'(rd_count), 32'(exp_rd));
        chk("R8 writes after table", 32'(wr_count), 32'(exp_wr));

        // R6: write acknowledgement enabled
        wr_ack_en = 1'b1;
        send(1, 1'b1, 4'd2, 16'h2222, 4'd5, 2'd1, 6'd7);
        mirror[1][2] = 16'h2222;
        exp_wr++;
        chk("R6 ack valid", 32'(rsp_valid[1]), 32'h1);
        chk("R6 ack kind", 32'(rsp_write[1]), 32'h1);
        chk("R6 R4 ack tag", 32'(rsp_tag[1]), 32'h5);
        chk("R6 R4 ack uid", 32'(rsp_uid[1]), 32'h7);
        wr_ack_en = 1'b0;
        @(negedge clk);

        // R7: back-pressure on bank 0
        rsp_ready[0] = 1'b0;
        send(0, 1'b0, 4'd3, 16'h0, 4'd9, 2'd2, 6'd9);
        exp_rd++;
        chk("R7 held rsp valid", 32'(rsp_valid[0]), 32'h1);
        chk("R7 held rsp data", 32'(rsp_data[0]), 32'h1234);
        req_valid[0] = 1'b1;
        req_write[0] = 1'b1;
        req_line[0]  = 4'd7;
        req_wdata[0] = 16'h7777;
        req_tag[0]   = 4'd2;
        #1;
        chk("R7 R2 ready low while held", 32'(req_ready[0]), 32'h0);
        @(posedge clk);
        @(negedge clk);
        chk("R7 still valid", 32'(rsp_valid[0]), 32'h1);
        chk("R7 tag stable", 32'(rsp_tag[0]), 32'h9);
        chk("R7 data stable", 32'(rsp_data[0]), 32'h1234);
        chk("R7 R8 blocked write not counted", 32'(wr_count), 32'(exp_wr));
        rsp_ready[0] = 1'b1;
        #1;
        chk("R2 ready when taken", 32'(req_ready[0]), 32'h1);
        @(posedge clk);
        @(negedge clk);
        req_valid[0] = 1'b0;
        mirror[0][7] = 16'h7777;
        exp_wr++;
        chk("R5 R2 write accepted silent", 32'(rsp_valid[0]), 32'h0);
        chk("R8 write counted", 32'(wr_count), 32'(exp_wr));
        send(0, 1'b0, 4'd7, 16'h0, 4'd3, 2'd0, 6'd1);
        exp_rd++;
        chk("R5 stored word", 32'(rsp_data[0]), 32'h7777);
        @(negedge clk);

        // R1: all banks read in one cycle
        req_write = '0;
        req_line  = {4'd15, 4'd0, 4'd2, 4'd3};
        req_tag   = {4'd13, 4'd12, 4'd11, 4'd10};
        req_valid = '1;
        @(posedge clk);
        @(negedge clk);
        req_valid = '0;
        exp_rd += 4;
        chk("R1 all valid", 32'(rsp_valid), 32'hF);
        chk("R1 bank0 data", 32'(rsp_data[0]), 32'(mirror[0][3]));
        chk("R1 bank1 data", 32'(rsp_data[1]), 32'(mirror[1][2]));
        chk("R1 bank2 data", 32'(rsp_data[2]), 32'(mirror[2][0]));
        chk("R1 bank3 data", 32'(rsp_data[3]), 32'(mirror[3][15]));
        chk("R1 R4 bank3 tag", 32'(rsp_tag[3]), 32'd13);
        chk("R8 multi-read count", 32'(rd_count), 32'(exp_rd));

        // R9: stall figure
        xbar_collisions = 16'd77;
        #1;
        chk("R9 stall passthrough", 32'(stall_count), 32'd77);
        xbar_collisions = 16'd65535;
        #1;
        chk("R9 stall passthrough max", 32'(stall_count), 32'd65535);

        // R10: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R10 counters cleared", 32'(rd_count), 32'h0);
        chk("R10 write counter cleared", 32'(wr_count), 32'h0);
        chk("R10 ready after reset", 32'(req_ready), 32'hF);

        finish_up();
    end

endmodule